// File: doc/BRIEF.md
# Effective Address Calculation Sequencer

This block turns the address part of an 18-bit memory-reference instruction into the final 15-bit data address. Memory is split into 4K-word core modules, and the upper three address bits select the module. Depending on the addressing mode, the instruction's indirect bit, the extend flag and the arithmetic mode, the sequencer does one of four things. It can pass the address through unchanged, add the index register to it, follow a chain of pointers through memory, or both index and follow pointers, in either order. Each pointer fetch is one read on a simple synchronous memory port. The read data arrives one clock after the request.

A controller pulses `start` with the instruction and the processor state. When the address is ready, the sequencer raises `done` for one cycle. In that cycle it presents the address and the number of pointer reads it spent. The core is a five-state machine:

- IDLE waits for `start`.
- INDEX performs the index addition.
- DEFER_REQ issues a pointer read.
- DEFER_WAIT takes the returned word.
- DONE presents the result.

The transitions are as follows:

- IDLE goes to INDEX (index first), to DEFER_REQ (defer first or defer only) or to DONE (direct).
- INDEX goes to DEFER_REQ when a defer is still pending, and to DONE otherwise.
- DEFER_REQ always goes to DEFER_WAIT.
- DEFER_WAIT goes back to DEFER_REQ (the chain continues), to INDEX (index after defer) or to DONE.
- DONE always returns to IDLE.

Top module: `eac_seq`

## Requirements
- R1: With no modification, the result is `epc` placed above `instr[11:0]`. No memory read occurs and the cycle count is 0.
- R2: With `ext_mode`=0, each pointer word is tested at bit 12 (the indirect bit; the instruction's indirect bit is also `instr[12]`). If that bit is set, another read follows at that word's bits 11:0. If it is clear, the chain ends. The upper three bits stay those of the core module the chain started in.
- R3: With `ext_mode`=1, exactly one pointer read occurs and its bits 14:0 become the address, whatever its bit 12.
- R4: `mem_cycles` equals the number of pointer reads made for the instruction. Reads are never issued in two consecutive cycles.
- R5: Indexing with `ext_mode`=0 adds `xr` to the 15-bit current address (core module bits included) and keeps the low 15 bits, so a carry can reach another module.
- R6: Indexing with `ext_mode`=1 and no prior pointer read adds `xr` to `instr[11:0]` alone and ignores `epc`.
- R7: With `ones_mode`=1 the index add is an 18-bit ones'-complement add with end-around carry. With `ones_mode`=0 it is twos'-complement.
- R8: `addr_mode` encoding: 0 is normal, 1 is base, 2 is index-first, 3 is defer-first. With base behaviour, the address is indexed unless `is_jump`=1. If `instr[12]` is set, the address is then dereferenced, with indexing first.
- R9: With normal behaviour, `instr[12]` selects deferral only. In modes 2 and 3 without `alt_once`, `instr[12]` selects indexing only. With the bit clear, the address is direct.
- R10: In modes 2 and 3 with `alt_once`=1, a deferral always occurs and `instr[12]` adds indexing. Mode 2 indexes before the pointer chain. Mode 3 indexes the address left by the last pointer read.
- R11: `alt_once`=1 makes mode 0 behave as base and mode 1 behave as normal.
- R12: `done` lasts one cycle. A `start` while the sequencer is busy is ignored and produces no further result. No read is issued while idle.
- R13: Indexing after a pointer read with `ext_mode`=1 uses the read word's bits 14:0 as the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address calculation (taken only when idle) |
| instr | input | 18 | Instruction word; bit 12 indirect, bits 11:0 address |
| epc | input | 3 | Current core module number |
| xr | input | 18 | Index register |
| addr_mode | input | 2 | 0 normal, 1 base, 2 index-first, 3 defer-first |
| alt_once | input | 1 | One-instruction alternate flag |
| ext_mode | input | 1 | Extend mode |
| ones_mode | input | 1 | 1 selects ones'-complement index add |
| is_jump | input | 1 | Instruction is a jump type |
| mem_rd_en | output | 1 | Pointer read request |
| mem_addr | output | 15 | Pointer read address |
| mem_rdata | input | 18 | Read data, valid the cycle after the request |
| done | output | 1 | Result strobe |
| eff_addr | output | 15 | Effective address, valid with `done` |
| mem_cycles | output | 6 | Pointer reads used, valid with `done` |

## Verification
Some properties hold on every clock and are checked by assertions:

- the one-cycle `done` pulse;
- the spacing of reads and the silence of the read port when idle;
- the counter moving only after a returned read;
- a non-extended chain staying inside its core module;
- an extended deferral never issuing a second read.

The address arithmetic needs the bench's scenarios to show it. This covers the ones'- versus twos'-complement sums, carries across a module boundary, the order of indexing and deferral in each mode, and the `alt_once` swaps. A start issued while busy also needs a scenario.

// File: rtl/eac_pkg.sv
package eac_pkg;
    localparam int WORD_W = 18;
    localparam int ADDR_W = 15;
    localparam int OFF_W  = 12;
    localparam int CORE_W = ADDR_W - OFF_W;
    localparam int IND_BIT = 12;

    typedef enum logic [1:0] {
        AM_NORMAL = 2'd0,
        AM_BASE   = 2'd1,
        AM_IFIRST = 2'd2,
        AM_DFIRST = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INDEX,
        ST_DEFER_REQ,
        ST_DEFER_WAIT,
        ST_DONE
    } state_e;
endpackage

// File: rtl/eac_mode_decode.sv
module eac_mode_decode
    import eac_pkg::*;
(
    input  logic [1:0] addr_mode,
    input  logic       alt_once,
    input  logic       ind_bit,
    input  logic       is_jump,
    output logic       do_index,
    output logic       do_defer,
    output logic       index_first
);
    amode_e mode;

    always_comb begin
        mode        = amode_e'(addr_mode);
        do_index    = 1'b0;
        do_defer    = 1'b0;
        index_first = 1'b1;
        unique case (mode)
            AM_NORMAL, AM_BASE: begin
                // alternate swaps the normal and base behaviours
                if ((mode == AM_BASE) ^ alt_once) begin
                    do_index = !is_jump;
                    do_defer = ind_bit;
                end else begin
                    do_defer = ind_bit;
                end
            end
            AM_IFIRST, AM_DFIRST: begin
                do_index    = ind_bit;
                do_defer    = alt_once;
                index_first = (mode == AM_IFIRST);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/eac_index_adder.sv
module eac_index_adder #(
    parameter int W  = 18,
    parameter int AW = 15
) (
    input  logic [AW-1:0] base_addr,
    input  logic [W-1:0]  index_val,
    input  logic          ones_mode,
    output logic [AW-1:0] sum_addr
);
    logic [W:0]   raw;
    logic [W-1:0] folded;

    always_comb begin
        raw    = {1'b0, {(W-AW){1'b0}}, base_addr} + {1'b0, index_val};
        folded = raw[W-1:0];
        if (ones_mode) begin
            folded = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
        end
        sum_addr = folded[AW-1:0];
    end
endmodule

// File: rtl/eac_cycle_counter.sv
module eac_cycle_counter #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          bump,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (bump) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/eac_seq.sv
module eac_seq
    import eac_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [WORD_W-1:0]   instr,
    input  logic [CORE_W-1:0]   epc,
    input  logic [WORD_W-1:0]   xr,
    input  logic [1:0]          addr_mode,
    input  logic                alt_once,
    input  logic                ext_mode,
    input  logic                ones_mode,
    input  logic                is_jump,
    output logic                mem_rd_en,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                done,
    output logic [ADDR_W-1:0]   eff_addr,
    output logic [CNT_W-1:0]    mem_cycles
);
    state_e state_q, state_d;

    logic [ADDR_W-1:0] cur_q;
    logic [WORD_W-1:0] xr_q;
    logic              ext_q, ones_q;
    logic              idx_after_q, def_after_q, deferred_q;

    logic              dec_index, dec_defer, dec_ifirst;
    logic [ADDR_W-1:0] idx_operand, idx_sum;
    logic              accept, chain_more;

    eac_mode_decode u_decode (
        .addr_mode   (addr_mode),
        .alt_once    (alt_once),
        .ind_bit     (instr[IND_BIT]),
        .is_jump     (is_jump),
        .do_index    (dec_index),
        .do_defer    (dec_defer),
        .index_first (dec_ifirst)
    );

    assign idx_operand = (ext_q && !deferred_q) ? {{CORE_W{1'b0}}, cur_q[OFF_W-1:0]} : cur_q;

    eac_index_adder #(.W(WORD_W), .AW(ADDR_W)) u_adder (
        .base_addr (idx_operand),
        .index_val (xr_q),
        .ones_mode (ones_q),
        .sum_addr  (idx_sum)
    );

    assign accept     = (state_q == ST_IDLE) && start;
    assign chain_more = !ext_q && mem_rdata[IND_BIT];

    eac_cycle_counter #(.CW(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .bump  (state_q == ST_DEFER_WAIT),
        .count (mem_cycles)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (dec_index && (dec_ifirst || !dec_defer)) state_d = ST_INDEX;
                    else if (dec_defer)                           state_d = ST_DEFER_REQ;
                    else                                          state_d = ST_DONE;
                end
            end
            ST_INDEX:      state_d = def_after_q ? ST_DEFER_REQ : ST_DONE;
            ST_DEFER_REQ:  state_d = ST_DEFER_WAIT;
            ST_DEFER_WAIT: begin
                if (chain_more)       state_d = ST_DEFER_REQ;
                else if (idx_after_q) state_d = ST_INDEX;
                else                  state_d = ST_DONE;
            end
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            xr_q        <= '0;
            ext_q       <= 1'b0;
            ones_q      <= 1'b0;
            idx_after_q <= 1'b0;
            def_after_q <= 1'b0;
            deferred_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cur_q       <= {epc, instr[OFF_W-1:0]};
                        xr_q        <= xr;
                        ext_q       <= ext_mode;
                        ones_q      <= ones_mode;
                        deferred_q  <= 1'b0;
                        def_after_q <= dec_defer && dec_index && dec_ifirst;
                        idx_after_q <= dec_index && dec_defer && !dec_ifirst;
                    end
                end
                ST_INDEX: begin
                    cur_q <= idx_sum;
                end
                ST_DEFER_REQ: ;
                ST_DEFER_WAIT: begin
                    if (ext_q) begin
                        cur_q <= mem_rdata[ADDR_W-1:0];
                    end else begin
                        cur_q <= {cur_q[ADDR_W-1:OFF_W], mem_rdata[OFF_W-1:0]};
                    end
                    if (!chain_more) begin
                        deferred_q <= 1'b1;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd_en = (state_q == ST_DEFER_REQ);
        mem_addr  = cur_q;
        done      = (state_q == ST_DONE);
        eff_addr  = cur_q;
    end
endmodule

// File: rtl/eac_seq_chk.sv
module eac_seq_chk
    import eac_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input state_e            state_q,
    input logic              ext_q,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic [CNT_W-1:0]  mem_cycles
);
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !mem_rd_en);

    p_read_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_DEFER_WAIT && $past(state_q) != ST_IDLE)
        |-> $stable(mem_cycles));

    p_core_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !ext_q && $past(state_q) == ST_DEFER_WAIT)
        |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])));

    p_ext_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_q && state_q == ST_DEFER_WAIT) |=> (state_q != ST_DEFER_REQ));
endmodule

bind eac_seq eac_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .ext_q      (ext_q),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .done       (done),
    .mem_cycles (mem_cycles)
);

// File: tb/eac_seq_bench.sv
module eac_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [17:0] instr = '0;
    logic [2:0]  epc = '0;
    logic [17:0] xr = '0;
    logic [1:0]  addr_mode = '0;
    logic        alt_once = 1'b0;
    logic        ext_mode = 1'b0;
    logic        ones_mode = 1'b0;
    logic        is_jump = 1'b0;
    logic        mem_rd_en;
    logic [14:0] mem_addr;
    logic [17:0] mem_rdata = '0;
    logic        done;
    logic [14:0] eff_addr;
    logic [5:0]  mem_cycles;

    int checks = 0;
    int errors = 0;
    int seen = 0;
    int cyc = 0;

    typedef struct {
        logic [14:0] ea;
        logic [5:0]  n;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [17:0] mem [int];

    always #5 clk = ~clk;

    eac_seq u_eac_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .epc(epc),
        .xr(xr), .addr_mode(addr_mode), .alt_once(alt_once), .ext_mode(ext_mode),
        .ones_mode(ones_mode), .is_jump(is_jump), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
        .eff_addr(eff_addr), .mem_cycles(mem_cycles)
    );

    // memory model, one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 18'o0;
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R12 unexpected result: actual ea=%o expected none", eff_addr);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (eff_addr !== e.ea || mem_cycles !== e.n) begin
                    errors++;
                    $display("FAIL %s: actual ea=%o cyc=%0d expected ea=%o cyc=%0d",
                             e.tag, eff_addr, mem_cycles, e.ea, e.n);
                end
            end
            seen++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run(input logic [17:0] i, input logic [2:0] e, input logic [17:0] x,
                       input logic [1:0] m, input logic a, input logic ex, input logic on,
                       input logic j, input logic [14:0] ea, input logic [5:0] n,
                       input string tag, input logic poke_busy = 1'b0);
        exp_t it;
        int target;
        it.ea = ea; it.n = n; it.tag = tag;
        sb.push_back(it);
        target = seen + 1;
        @(negedge clk);
        instr = i; epc = e; xr = x; addr_mode = m; alt_once = a;
        ext_mode = ex; ones_mode = on; is_jump = j; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            @(negedge clk);
            instr = 18'o200777; epc = 3'd5; addr_mode = 2'd0; alt_once = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (seen == target);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        mem[15'o21234] = 18'o052105;
        mem[15'o22105] = 18'o013224;
        mem[15'o23224] = 18'o004256;
        mem[15'o00030] = 18'o010105;
        mem[15'o00105] = 18'o001234;
        mem[15'o01234] = 18'o000003;
        mem[15'o30130] = 18'o011234;
        mem[15'o31234] = 18'o062345;
        mem[15'o10130] = 18'o031234;
        mem[15'o20030] = 18'o011234;
        mem[15'o01234] = 18'o000003;

        repeat (3) @(negedge clk);
        checks++;
        if (done !== 1'b0 || mem_rd_en !== 1'b0 || mem_cycles !== 6'd0) begin
            errors++;
            $display("FAIL R12 reset: actual done=%b rd=%b cyc=%0d expected 0 0 0",
                     done, mem_rd_en, mem_cycles);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 direct
        run(18'o201234, 3'd1, 18'o0, 2'd0, 0, 0, 0, 0, 15'o11234, 6'd0, "R1 direct");
        // R2 multi-level chain in core 2 (memory 21234 -> 22105 -> 23224)
        mem[15'o21234] = 18'o052105;
        run(18'o211234, 3'd2, 18'o0, 2'd0, 0, 0, 0, 0, 15'o24256, 6'd3, "R2 chain");
        // R2/R4 chain in core 0
        run(18'o210030, 3'd0, 18'o0, 2'd0, 0, 0, 0, 0, 15'o01234, 6'd2, "R4 two reads");
        // R3 extended single deferral
        run(18'o210030, 3'd0, 18'o0, 2'd0, 0, 1, 0, 0, 15'o10105, 6'd1, "R3 ext defer");
        // R5 index crosses modules
        run(18'o200030, 3'd2, 18'o010100, 2'd1, 0, 0, 0, 0, 15'o30130, 6'd0, "R5 index carry");
        // R6 extended index ignores epc
        run(18'o200030, 3'd2, 18'o010100, 2'd1, 0, 1, 0, 0, 15'o10130, 6'd0, "R6 ext index");
        // R7 ones' vs twos'
        run(18'o200070, 3'd0, 18'o777770, 2'd1, 0, 0, 1, 0, 15'o00061, 6'd0, "R7 ones");
        run(18'o200070, 3'd0, 18'o777770, 2'd1, 0, 0, 0, 0, 15'o00060, 6'd0, "R7 twos");
        // R8 base: index then chain
        run(18'o210030, 3'd2, 18'o010100, 2'd1, 0, 0, 0, 0, 15'o32345, 6'd2, "R8 base ind");
        run(18'o210030, 3'd2, 18'o010100, 2'd1, 0, 1, 0, 0, 15'o31234, 6'd1, "R8 base ext");
        // R8 jump: no index
        mem[15'o21234] = 18'o002345;
        run(18'o210030, 3'd2, 18'o010100, 2'd1, 0, 0, 0, 1, 15'o22345, 6'd2, "R8 jump ind");
        run(18'o200030, 3'd2, 18'o010100, 2'd1, 0, 0, 0, 1, 15'o20030, 6'd0, "R8 jump");
        // R9 normal mode and non-alternated index/defer modes
        run(18'o200030, 3'd2, 18'o010100, 2'd0, 0, 0, 0, 0, 15'o20030, 6'd0, "R9 normal");
        run(18'o210030, 3'd2, 18'o010100, 2'd2, 0, 0, 0, 0, 15'o30130, 6'd0, "R9 ifirst i");
        run(18'o210030, 3'd2, 18'o010100, 2'd3, 0, 0, 0, 0, 15'o30130, 6'd0, "R9 dfirst i");
        run(18'o200030, 3'd2, 18'o010100, 2'd2, 0, 0, 0, 0, 15'o20030, 6'd0, "R9 ifirst no i");
        // R10 alternated index-first / defer-first
        run(18'o210030, 3'd2, 18'o010100, 2'd2, 1, 0, 0, 0, 15'o32345, 6'd2, "R10 alt ifirst");
        run(18'o210030, 3'd2, 18'o010100, 2'd3, 1, 0, 0, 0, 15'o32445, 6'd2, "R10 alt dfirst");
        run(18'o200030, 3'd0, 18'o010100, 2'd3, 1, 0, 0, 0, 15'o01234, 6'd2, "R10 alt no i");
        // R13 extended defer then index
        run(18'o210030, 3'd2, 18'o010100, 2'd3, 1, 1, 0, 0, 15'o21334, 6'd1, "R13 ext dfirst");
        // R11 alternate swaps normal and base
        run(18'o200030, 3'd2, 18'o010100, 2'd0, 1, 0, 0, 0, 15'o30130, 6'd0, "R11 alt normal");
        run(18'o200030, 3'd2, 18'o010100, 2'd1, 1, 0, 0, 0, 15'o20030, 6'd0, "R11 alt base");
        // R12 start while busy is ignored
        mem[15'o21234] = 18'o052105;
        run(18'o211234, 3'd2, 18'o0, 2'd0, 0, 0, 0, 0, 15'o24256, 6'd3, "R12 busy", 1'b1);
        repeat (10) @(negedge clk);
        checks++;
        if (sb.size() != 0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R12 after busy: actual pending=%0d done=%b expected 0 0",
                     sb.size(), done);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule